// File: doc/BRIEF.md
# Audio Link Sleep and Wake Sequencer

This block sits on the controller side of an AC'97-style serial audio link and handles the link's low-power transitions. When software requests sleep, it sends one outgoing frame over SYNC and SDATA_OUT. That frame writes the value 0x1000 to codec register 0x26, and every data slot after the command slots is left empty. After the frame, the block drives both link outputs low and treats the link as asleep.

While the link is asleep, BITCLK from the codec is stopped. All sleep-state timing therefore runs on a free-running reference clock, `clk_ref`. The parameter `US_CYCLES` gives the number of reference cycles in one microsecond. A codec requests wake-up by holding SDATA_IN high for longer than that time. The block qualifies the pulse and can raise a sticky resume interrupt. On a software command it then sends a warm reset, which is a timed SYNC pulse sent while BITCLK is still absent. The block returns to normal running once BITCLK edges appear again.

Software drives the block through a single write strobe with four command bits. It reads back status on level outputs. BITCLK and SDATA_IN each pass through a two-flop synchronizer into the reference clock domain.

Top module: `alink_pm_seq`

## Requirements
- R1: A write with `wr_data[0]` set starts the sleep sequence. `link_state` goes from RUN (0) to PD_WRITE (1) on the clock edge that registers the write. The same command in any other state is ignored.
- R2: In PD_WRITE, each synchronized BITCLK rising edge presents one frame bit, MSB first, for 256 bits in total.
  - SYNC is high for the first 16 bits.
  - The 16-bit tag is 0xE000: frame valid, slot 1 valid and slot 2 valid.
  - The 20-bit command slot is 0x26000: bit 19 = 0 for a write, and address 0x26 in bits 18:12.
  - The 20-bit data slot is 0x10000: value 0x1000 in bits 19:4.
  - All remaining 200 bits are 0.
- R3: The first BITCLK rising edge after the 256th bit moves `link_state` to ASLEEP (2). At that point SYNC and SDATA_OUT are low.
- R4: In ASLEEP, SDATA_IN held high for more than `US_CYCLES` reference cycles moves `link_state` to WAKE_SEEN (3). A pulse of `US_CYCLES` cycles or fewer is ignored.
- R5: A qualified wake sets `resume_irq` only when `resume_en` is 1. With `resume_en` at 0, the state still advances but the interrupt stays clear.
- R6: `resume_irq` stays set until a write with `wr_data[2]` set clears it.
- R7: A write with `wr_data[1]` set in ASLEEP or WAKE_SEEN enters WARM_RESET (4). In WARM_RESET, SYNC is high for exactly `US_CYCLES` reference cycles and SDATA_OUT stays low.
- R8: After SYNC falls, the block stays in WARM_RESET until the first synchronized BITCLK rising edge, which returns it to RUN (0).
- R9: A warm-reset command in RUN leaves the state unchanged and sets `wake_err`. A write with `wr_data[3]` set clears `wake_err`.
- R10: After reset, `link_state` is RUN (0), and SYNC, SDATA_OUT, `resume_irq` and `wake_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock from the codec (absent while asleep) |
| sdata_in | input | 1 | Serial data from the codec, used as the wake line |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 4 | Command bits: 0 sleep, 1 warm reset, 2 clear interrupt, 3 clear error |
| resume_en | input | 1 | Resume interrupt enable for the codec |
| sync | output | 1 | Link SYNC output |
| sdata_out | output | 1 | Serial data toward the codec |
| resume_irq | output | 1 | Sticky resume interrupt |
| wake_err | output | 1 | Sticky flag for a warm-reset command issued in RUN |
| link_state | output | 3 | Sequencer state code |

## Verification
The hardest point to reach is the wake-width boundary in ASLEEP. Getting there takes a full 256-bit sleep frame clocked in by bench-generated BITCLK pulses. Then SDATA_IN pulses of exactly `US_CYCLES` and `US_CYCLES`+1 reference cycles must tell an ignored glitch from a real wake. The bench walks the whole sleep, wake and warm-reset loop twice, once with the resume enable off and once with it on. It measures the warm-reset SYNC width cycle by cycle.

// File: rtl/alink_pm_pkg.sv
package alink_pm_pkg;

    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_PD_WRITE   = 3'd1,
        ST_ASLEEP     = 3'd2,
        ST_WAKE_SEEN  = 3'd3,
        ST_WARM_RESET = 3'd4
    } link_state_e;

    // frame geometry
    localparam int TAG_BITS   = 16;
    localparam int SLOT_BITS  = 20;
    localparam int DATA_SLOTS = 12;
    localparam int FRAME_BITS = TAG_BITS + DATA_SLOTS * SLOT_BITS;
    localparam int HEAD_BITS  = TAG_BITS + 2 * SLOT_BITS;

    // sleep command content
    localparam logic [6:0]  SLEEP_REG_ADDR = 7'h26;
    localparam logic [15:0] SLEEP_REG_VAL  = 16'h1000;
    localparam logic [15:0] SLEEP_TAG      = 16'hE000;
    localparam logic [SLOT_BITS-1:0] SLEEP_CMD_SLOT  = {1'b0, SLEEP_REG_ADDR, 12'h000};
    localparam logic [SLOT_BITS-1:0] SLEEP_DATA_SLOT = {SLEEP_REG_VAL, 4'h0};

    // command bit positions
    localparam int WR_W       = 4;
    localparam int WB_SLEEP   = 0;
    localparam int WB_WARM    = 1;
    localparam int WB_CLR_IRQ = 2;
    localparam int WB_CLR_ERR = 3;

endpackage

// File: rtl/alink_sync2.sv
module alink_sync2 #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta   = d;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.stable;

endmodule

// File: rtl/alink_hold_timer.sv
module alink_hold_timer #(
    parameter int LIMIT = 50,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             done
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign done  = (t_q.cnt == CNT_W'(LIMIT));
    assign count = t_q.cnt;

    always_comb begin
        t_d = t_q;
        if (clear)      t_d.cnt = '0;
        else if (!done) t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

endmodule

// File: rtl/alink_pd_frame.sv
module alink_pd_frame
    import alink_pm_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic [IDX_W-1:0] bit_idx,
    output logic             frame_bit,
    output logic             frame_sync
);

    localparam int HEAD_IDX_W = $clog2(HEAD_BITS);
    localparam logic [HEAD_BITS-1:0] HEAD_VEC = {SLEEP_TAG, SLEEP_CMD_SLOT, SLEEP_DATA_SLOT};

    always_comb begin
        frame_sync = (bit_idx < IDX_W'(TAG_BITS));
        if (bit_idx < IDX_W'(HEAD_BITS))
            frame_bit = HEAD_VEC[HEAD_IDX_W'(HEAD_BITS - 1) - bit_idx[HEAD_IDX_W-1:0]];
        else
            frame_bit = 1'b0;
    end

endmodule

// File: rtl/alink_pm_seq.sv
module alink_pm_seq
    import alink_pm_pkg::*;
#(
    parameter int US_CYCLES = 50
) (
    input  logic            clk_ref,
    input  logic            rst_n,
    input  logic            bit_clk,
    input  logic            sdata_in,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    input  logic            resume_en,
    output logic            sync,
    output logic            sdata_out,
    output logic            resume_irq,
    output logic            wake_err,
    output logic [2:0]      link_state
);

    localparam int IDX_W = $clog2(FRAME_BITS + 1);
    localparam int TMR_W = $clog2(US_CYCLES + 1);

    typedef struct packed {
        link_state_e      state;
        logic             bclk_prev;
        logic             sdo;
        logic             sync;
        logic [IDX_W-1:0] bit_idx;
        logic             irq;
        logic             err;
    } seq_t;

    seq_t r_d, r_q;

    logic             bclk_s, sdi_s;
    logic             bclk_rise;
    logic             pd_bit, pd_sync;
    logic             tmr_clear, tmr_done;
    logic [TMR_W-1:0] tmr_count;
    logic             cmd_sleep, cmd_warm;

    alink_sync2 #(.WIDTH(2)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     ({sdata_in, bit_clk}),
        .q     ({sdi_s, bclk_s})
    );

    alink_pd_frame #(.IDX_W(IDX_W)) u_frame (
        .bit_idx    (r_q.bit_idx),
        .frame_bit  (pd_bit),
        .frame_sync (pd_sync)
    );

    // one timer serves both the wake-width check and the SYNC pulse width
    alink_hold_timer #(.LIMIT(US_CYCLES), .CNT_W(TMR_W)) u_timer (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .count (tmr_count),
        .done  (tmr_done)
    );

    assign bclk_rise = bclk_s & ~r_q.bclk_prev;
    assign cmd_sleep = wr_en & wr_data[WB_SLEEP];
    assign cmd_warm  = wr_en & wr_data[WB_WARM];

    always_comb begin
        r_d           = r_q;
        r_d.bclk_prev = bclk_s;

        if (wr_en && wr_data[WB_CLR_IRQ]) r_d.irq = 1'b0;
        if (wr_en && wr_data[WB_CLR_ERR]) r_d.err = 1'b0;

        unique case (r_q.state)
            ST_RUN: begin
                if (cmd_warm) r_d.err = 1'b1;
                if (cmd_sleep) begin
                    r_d.state   = ST_PD_WRITE;
                    r_d.bit_idx = '0;
                    r_d.sdo     = 1'b0;
                    r_d.sync    = 1'b0;
                end
            end
            ST_PD_WRITE: begin
                if (bclk_rise) begin
                    if (r_q.bit_idx == IDX_W'(FRAME_BITS)) begin
                        r_d.state = ST_ASLEEP;
                        r_d.sdo   = 1'b0;
                        r_d.sync  = 1'b0;
                    end else begin
                        r_d.sdo     = pd_bit;
                        r_d.sync    = pd_sync;
                        r_d.bit_idx = r_q.bit_idx + 1'b1;
                    end
                end
            end
            ST_ASLEEP: begin
                if (tmr_done && sdi_s) begin
                    r_d.state = ST_WAKE_SEEN;
                    if (resume_en) r_d.irq = 1'b1;
                end
                if (cmd_warm) begin
                    r_d.state = ST_WARM_RESET;
                    r_d.sync  = 1'b1;
                    r_d.sdo   = 1'b0;
                end
            end
            ST_WAKE_SEEN: begin
                if (cmd_warm) begin
                    r_d.state = ST_WARM_RESET;
                    r_d.sync  = 1'b1;
                    r_d.sdo   = 1'b0;
                end
            end
            ST_WARM_RESET: begin
                if (!tmr_done) begin
                    if (tmr_count == TMR_W'(US_CYCLES - 1)) r_d.sync = 1'b0;
                end else if (bclk_rise) begin
                    r_d.state = ST_RUN;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_comb begin
        tmr_clear = 1'b1;
        if ((r_q.state == ST_ASLEEP && sdi_s) || r_q.state == ST_WARM_RESET)
            tmr_clear = 1'b0;
        if (r_d.state != r_q.state)
            tmr_clear = 1'b1;
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sync       = r_q.sync;
    assign sdata_out  = r_q.sdo;
    assign resume_irq = r_q.irq;
    assign wake_err   = r_q.err;
    assign link_state = r_q.state;

endmodule

// File: rtl/alink_pm_seq_chk.sv
module alink_pm_seq_chk
    import alink_pm_pkg::*;
(
    input logic            clk_ref,
    input logic            rst_n,
    input logic            wr_en,
    input logic [WR_W-1:0] wr_data,
    input logic            resume_en,
    input logic            sync,
    input logic            sdata_out,
    input logic            resume_irq,
    input logic            wake_err,
    input logic [2:0]      link_state
);

    AST_SLEEP_ENTRY: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (wr_en && wr_data[WB_SLEEP] && link_state == 3'(ST_RUN)) |=> link_state == 3'(ST_PD_WRITE)); // R1

    AST_LINK_QUIET: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (link_state == 3'(ST_ASLEEP) || link_state == 3'(ST_WAKE_SEEN)) |-> (!sync && !sdata_out)); // R3

    AST_WAKE_FROM_SLEEP: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (link_state == 3'(ST_WAKE_SEEN) && $past(link_state) != 3'(ST_WAKE_SEEN)) |-> $past(link_state) == 3'(ST_ASLEEP)); // R4

    AST_IRQ_ENABLED: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(resume_irq) |-> $past(resume_en)); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (resume_irq && !(wr_en && wr_data[WB_CLR_IRQ])) |=> resume_irq); // R6

    AST_SYNC_SOURCE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        sync |-> (link_state == 3'(ST_PD_WRITE) || link_state == 3'(ST_WARM_RESET))); // R7

    AST_RUN_AFTER_SYNC: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (link_state == 3'(ST_RUN) && $past(link_state) == 3'(ST_WARM_RESET)) |-> $past(!sync)); // R8

    AST_ERR_SOURCE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(wake_err) |-> ($past(link_state) == 3'(ST_RUN) && $past(wr_en && wr_data[WB_WARM]))); // R9

    AST_ERR_CLEAR: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (wr_en && wr_data[WB_CLR_ERR] && !(wr_data[WB_WARM] && link_state == 3'(ST_RUN))) |=> !wake_err); // R9

endmodule

bind alink_pm_seq alink_pm_seq_chk u_chk (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .resume_en  (resume_en),
    .sync       (sync),
    .sdata_out  (sdata_out),
    .resume_irq (resume_irq),
    .wake_err   (wake_err),
    .link_state (link_state)
);

// File: tb/alink_pm_seq_test.sv
module alink_pm_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int US         = 20;
    localparam int BCLK_HALF  = 4;
    localparam int NBITS      = 256;

    logic       clk_ref   = 1'b0;
    logic       rst_n     = 1'b0;
    logic       bit_clk   = 1'b0;
    logic       sdata_in  = 1'b0;
    logic       wr_en     = 1'b0;
    logic [3:0] wr_data   = 4'h0;
    logic       resume_en = 1'b0;
    logic       sync, sdata_out, resume_irq, wake_err;
    logic [2:0] link_state;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct packed { logic s; logic d; } fbit_t;
    fbit_t exp_q[$];
    event  smp_ev;

    always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

    alink_pm_seq #(.US_CYCLES(US)) uut (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .bit_clk    (bit_clk),
        .sdata_in   (sdata_in),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .resume_en  (resume_en),
        .sync       (sync),
        .sdata_out  (sdata_out),
        .resume_irq (resume_irq),
        .wake_err   (wake_err),
        .link_state (link_state)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic fbit_t exp_fbit(input int i);
        logic [55:0] head;
        fbit_t e;
        head = {16'hE000, 1'b0, 7'h26, 12'h000, 16'h1000, 4'h0};
        e.s  = (i < 16);
        e.d  = (i < 56) ? head[55 - i] : 1'b0;
        return e;
    endfunction

    // driver side of the scoreboard
    task automatic push_frame();
        for (int i = 0; i < NBITS; i++) exp_q.push_back(exp_fbit(i));
    endtask

    task automatic reg_write(input logic [3:0] v);
        @(negedge clk_ref);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk_ref);
        wr_en = 1'b0; wr_data = 4'h0;
    endtask

    task automatic bclk_pulse();
        @(negedge clk_ref);
        bit_clk = 1'b1;
        repeat (BCLK_HALF) @(negedge clk_ref);
        -> smp_ev;
        bit_clk = 1'b0;
        repeat (BCLK_HALF) @(negedge clk_ref);
    endtask

    // monitor side of the scoreboard
    always @(smp_ev) begin
        fbit_t e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check("R2 sync bit", 32'(sync), 32'(e.s));
            check("R2 sdata_out bit", 32'(sdata_out), 32'(e.d));
        end
    end

    task automatic run_frame();
        push_frame();
        repeat (NBITS) bclk_pulse();
        check("R2 all frame bits consumed", 32'(exp_q.size()), 32'd0);
        bclk_pulse();
        check("R3 state asleep", 32'(link_state), 32'd2);
        check("R3 sync low", 32'(sync), 32'd0);
        check("R3 sdata_out low", 32'(sdata_out), 32'd0);
    endtask

    task automatic warm_reset_and_check();
        int width;
        @(negedge clk_ref);
        wr_en = 1'b1; wr_data = 4'b0010;
        @(negedge clk_ref);
        wr_en = 1'b0; wr_data = 4'h0;
        check("R7 state warm reset", 32'(link_state), 32'd4);
        check("R7 sdata_out low", 32'(sdata_out), 32'd0);
        width = 0;
        while (sync === 1'b1 && width < 1000) begin
            width++;
            @(negedge clk_ref);
        end
        check("R7 sync width", 32'(width), 32'(US));
        sdata_in = 1'b0;
        repeat (10) @(negedge clk_ref);
        check("R8 waits for bit clock", 32'(link_state), 32'd4);
        bclk_pulse();
        check("R8 back to run", 32'(link_state), 32'd0);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk_ref);
        rst_n = 1'b1;
        @(negedge clk_ref);
        check("R10 reset state", 32'(link_state), 32'd0);
        check("R10 reset sync", 32'(sync), 32'd0);
        check("R10 reset sdata_out", 32'(sdata_out), 32'd0);
        check("R10 reset irq", 32'(resume_irq), 32'd0);
        check("R10 reset err", 32'(wake_err), 32'd0);

        reg_write(4'b0010);
        check("R9 warm in run sets err", 32'(wake_err), 32'd1);
        check("R9 warm in run keeps state", 32'(link_state), 32'd0);
        reg_write(4'b1000);
        check("R9 err cleared", 32'(wake_err), 32'd0);

        reg_write(4'b0001);
        check("R1 sleep accepted", 32'(link_state), 32'd1);
        run_frame();
        reg_write(4'b0001);
        check("R1 sleep ignored when asleep", 32'(link_state), 32'd2);

        // wake with interrupt disabled; codec holds the line high
        resume_en = 1'b0;
        @(negedge clk_ref);
        sdata_in = 1'b1;
        repeat (US + 10) @(negedge clk_ref);
        check("R4 long wake seen", 32'(link_state), 32'd3);
        check("R5 irq stays off when disabled", 32'(resume_irq), 32'd0);
        warm_reset_and_check();

        // second round with interrupt enabled
        reg_write(4'b0001);
        check("R1 sleep accepted again", 32'(link_state), 32'd1);
        run_frame();
        resume_en = 1'b1;
        @(negedge clk_ref);
        sdata_in = 1'b1;
        repeat (US) @(negedge clk_ref);
        sdata_in = 1'b0;
        repeat (US + 5) @(negedge clk_ref);
        check("R4 pulse of US cycles ignored", 32'(link_state), 32'd2);
        check("R4 no irq on short pulse", 32'(resume_irq), 32'd0);

        sdata_in = 1'b1;
        repeat (US + 1) @(negedge clk_ref);
        sdata_in = 1'b0;
        repeat (6) @(negedge clk_ref);
        check("R4 pulse of US+1 cycles wakes", 32'(link_state), 32'd3);
        check("R5 irq raised when enabled", 32'(resume_irq), 32'd1);
        repeat (50) @(negedge clk_ref);
        check("R6 irq sticky", 32'(resume_irq), 32'd1);
        reg_write(4'b0100);
        check("R6 irq cleared by write", 32'(resume_irq), 32'd0);

        warm_reset_and_check();
        finish_run();
    end

endmodule